// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath unit that takes two operands and produces one result from four families of operation: addition-based arithmetic, bitwise logic, a one-place right shift and a one-place left shift. The width is a parameter with a default of 4 bits. The unit is a row of identical bit stages.

Each bit stage holds three parts:

- **Arithmetic part.** A full adder adds the A bit, a bit picked from the B operand by a small selector, and the incoming carry.
- **Logic part.** A gate network picks one of four bitwise results.
- **Output selector.** This picks among the arithmetic result, the logic result and the two neighbouring A bits.

The same low select pair drives both the operand selector and the logic selector. The high select pair picks the family.

Two serial inputs feed the vacated end bit of each shift. A surrounding datapath drives the operands from its registers and loads the result. It reads the carry-out and the overflow only after an arithmetic operation.

Top module: `alsu_unit`

## Requirements
- R1: With `op_sel[3:2]` = 00, the result is `f = a + y + cin` modulo 2^WIDTH. The value y depends on `op_sel[1:0]`: 00 gives b, 01 gives ~b, 10 gives all zeros, and 11 gives all ones.
- R2: Each arithmetic code yields a named operation. Code 00 is add (cin=0) or add plus one (cin=1). Code 01 is a-b-1 (cin=0) or a-b (cin=1). Code 10 passes a through (cin=0) or increments it (cin=1). Code 11 decrements a (cin=0) or passes it through (cin=1).
- R3: `cout` is the carry out of the most significant adder stage when `op_sel[3:2]` = 00, and is 0 for every other family.
- R4: `ovf` is the XOR of the carries into and out of the most significant stage when `op_sel[3:2]` = 00, and is 0 for every other family.
- R5: With `op_sel[3:2]` = 01, `op_sel[1:0]` picks the bitwise result and `cin` has no effect. The codes are 00 for a XOR b, 01 for a OR b, 10 for a AND b, and 11 for NOT a. Both `cout` and `ovf` are 0.
- R6: With `op_sel[3:2]` = 10, f[i] = a[i+1] for every bit below the top, and the top bit of f comes from `ser_right_in`. The low select bits, b and cin have no effect.
- R7: With `op_sel[3:2]` = 11, f[i] = a[i-1] for every bit above bit 0, and f[0] comes from `ser_left_in`. The low select bits, b and cin have no effect.
- R8: For subtraction (code 0001 with cin=1) and unsigned a < b, f equals 2^WIDTH - (b - a) and `cout` is 0. For a >= b, f equals a - b and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand; also the shift source |
| b | input | WIDTH | Second operand |
| op_sel | input | 4 | [3:2] family select, [1:0] operation within the family |
| cin | input | 1 | Carry into the least significant adder stage |
| ser_right_in | input | 1 | Bit shifted into the top position on a right shift |
| ser_left_in | input | 1 | Bit shifted into bit 0 on a left shift |
| f | output | WIDTH | Result |
| cout | output | 1 | Adder carry-out; 0 outside arithmetic |
| ovf | output | 1 | Signed overflow; 0 outside arithmetic |

## Verification
The assertions are immediate checks on settled combinational values. They assume every input is a known 0 or 1 at the moment they are evaluated. This holds because the bench drives every input, including both serial inputs and cin, from the first time step. It changes inputs only on the falling clock edge.

The sign-rule check on `ovf` assumes the operand selector's output is the true second addend. The bench covers every selector code against exhaustive operand pairs, so every addend pattern the rule depends on is reached.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
   // Family chosen by op_sel[3:2]
   localparam logic [1:0] FAM_ARITH = 2'b00;
   localparam logic [1:0] FAM_LOGIC = 2'b01;
   localparam logic [1:0] FAM_SHR   = 2'b10;
   localparam logic [1:0] FAM_SHL   = 2'b11;

   // Second addend chosen by op_sel[1:0] in the arithmetic family
   localparam logic [1:0] ADD_B     = 2'b00;
   localparam logic [1:0] ADD_NB    = 2'b01;
   localparam logic [1:0] ADD_ZERO  = 2'b10;
   localparam logic [1:0] ADD_ONES  = 2'b11;

   // Bitwise result chosen by op_sel[1:0] in the logic family
   localparam logic [1:0] BIT_XOR   = 2'b00;
   localparam logic [1:0] BIT_OR    = 2'b01;
   localparam logic [1:0] BIT_AND   = 2'b10;
   localparam logic [1:0] BIT_NOTA  = 2'b11;
endpackage

// File: rtl/alsu_arith_bit.sv
module alsu_arith_bit
   import alsu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic       c_i,
   input  logic [1:0] fn_i,
   output logic       y_o,
   output logic       d_o,
   output logic       c_o
);
   always_comb begin
      unique case (fn_i)
         ADD_B:    y_o = b_i;
         ADD_NB:   y_o = ~b_i;
         ADD_ZERO: y_o = 1'b0;
         default:  y_o = 1'b1;
      endcase
   end

   // full adder
   assign d_o = a_i ^ y_o ^ c_i;
   assign c_o = (a_i & y_o) | ((a_i ^ y_o) & c_i);
endmodule

// File: rtl/alsu_logic_bit.sv
module alsu_logic_bit
   import alsu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic [1:0] fn_i,
   output logic       e_o
);
   always_comb begin
      unique case (fn_i)
         BIT_XOR: e_o = a_i ^ b_i;
         BIT_OR:  e_o = a_i | b_i;
         BIT_AND: e_o = a_i & b_i;
         default: e_o = ~a_i;
      endcase
   end
endmodule

// File: rtl/alsu_out_bit.sv
module alsu_out_bit
   import alsu_pkg::*;
(
   input  logic [1:0] fam_i,
   input  logic       d_i,
   input  logic       e_i,
   input  logic       shr_i,
   input  logic       shl_i,
   output logic       f_o
);
   always_comb begin
      unique case (fam_i)
         FAM_ARITH: f_o = d_i;
         FAM_LOGIC: f_o = e_i;
         FAM_SHR:   f_o = shr_i;
         default:   f_o = shl_i;
      endcase
   end
endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
   import alsu_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       op_sel,
   input  logic             cin,
   input  logic             ser_right_in,
   input  logic             ser_left_in,
   output logic [WIDTH-1:0] f,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("alsu_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic [1:0]       fam;
   logic [1:0]       fn;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] y_vec;
   logic [WIDTH-1:0] d_vec;
   logic [WIDTH-1:0] e_vec;
   logic [WIDTH-1:0] shr_vec;
   logic [WIDTH-1:0] shl_vec;

   assign fam      = op_sel[3:2];
   assign fn       = op_sel[1:0];
   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      alsu_arith_bit u_arith (
         .a_i  (a[i]),
         .b_i  (b[i]),
         .c_i  (carry[i]),
         .fn_i (fn),
         .y_o  (y_vec[i]),
         .d_o  (d_vec[i]),
         .c_o  (carry[i+1])
      );

      alsu_logic_bit u_logic (
         .a_i  (a[i]),
         .b_i  (b[i]),
         .fn_i (fn),
         .e_o  (e_vec[i])
      );

      if (i == MSB) begin : g_shr_top
         assign shr_vec[i] = ser_right_in;
      end else begin : g_shr_mid
         assign shr_vec[i] = a[i+1];
      end

      if (i == 0) begin : g_shl_bottom
         assign shl_vec[i] = ser_left_in;
      end else begin : g_shl_mid
         assign shl_vec[i] = a[i-1];
      end

      alsu_out_bit u_out (
         .fam_i (fam),
         .d_i   (d_vec[i]),
         .e_i   (e_vec[i]),
         .shr_i (shr_vec[i]),
         .shl_i (shl_vec[i]),
         .f_o   (f[i])
      );
   end

   assign cout = (fam == FAM_ARITH) ? carry[WIDTH] : 1'b0;
   assign ovf  = (fam == FAM_ARITH) ? (carry[WIDTH] ^ carry[MSB]) : 1'b0;

   // ---------------- assertions ----------------
   always_comb begin
      if (fam == FAM_ARITH) begin
         assert_arith_sum_R1: assert ({cout, f} ==
            ({1'b0, a} + {1'b0, y_vec} + {{WIDTH{1'b0}}, cin}))
            else $error("R1: adder row disagrees with a+y+cin");
         assert_ovf_sign_R4: assert (ovf ==
            ((a[MSB] == y_vec[MSB]) && (f[MSB] != a[MSB])))
            else $error("R4: overflow flag disagrees with sign rule");
      end else begin
         assert_carry_gated_R3: assert (cout == 1'b0)
            else $error("R3: carry-out active outside arithmetic");
         assert_no_overflow_R4: assert (ovf == 1'b0)
            else $error("R4: overflow active outside arithmetic");
      end
      if (fam == FAM_SHR) begin
         assert_shift_right_R6: assert ((f[MSB-1:0] == a[MSB:1]) &&
            (f[MSB] == ser_right_in))
            else $error("R6: right shift result wrong");
      end
      if (fam == FAM_SHL) begin
         assert_shift_left_R7: assert ((f[MSB:1] == a[MSB-1:0]) &&
            (f[0] == ser_left_in))
            else $error("R7: left shift result wrong");
      end
   end
endmodule

// File: tb/alsu_unit_bench.sv
module alsu_unit_bench;
   localparam int W = 4;
   localparam int N = 1 << W;

   logic         clk;
   logic [W-1:0] a, b, f;
   logic [3:0]   op_sel;
   logic         cin, sri, sli, cout, ovf;
   int           n_checks;
   int           n_fails;

   alsu_unit #(.WIDTH(W)) u_alsu_unit (
      .a(a), .b(b), .op_sel(op_sel), .cin(cin),
      .ser_right_in(sri), .ser_left_in(sli),
      .f(f), .cout(cout), .ovf(ovf)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   initial begin
      a = '0; b = '0; op_sel = '0; cin = 1'b0; sri = 1'b0; sli = 1'b0;
      n_checks = 0; n_fails = 0;
   end

   // Expected {f, cout, ovf}, computed from the requirements
   function automatic logic [W+1:0] model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                                          input logic [3:0] s, input logic c,
                                          input logic r, input logic l);
      logic [W-1:0] y, res;
      logic [W:0]   full;
      logic         co, v;
      co = 1'b0; v = 1'b0; res = '0;
      case (s[3:2])
         2'b00: begin
            case (s[1:0])
               2'b00: y = mb;
               2'b01: y = ~mb;
               2'b10: y = '0;
               default: y = '1;
            endcase
            full = {1'b0, ma} + {1'b0, y} + (W+1)'(c);
            res  = full[W-1:0];
            co   = full[W];
            v    = (ma[W-1] == y[W-1]) && (res[W-1] != ma[W-1]);
         end
         2'b01: begin
            case (s[1:0])
               2'b00: res = ma ^ mb;
               2'b01: res = ma | mb;
               2'b10: res = ma & mb;
               default: res = ~ma;
            endcase
         end
         2'b10: res = {r, ma[W-1:1]};
         default: res = {ma[W-2:0], l};
      endcase
      return {res, co, v};
   endfunction

   task automatic check(input string req, input logic [W+1:0] got, input logic [W+1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: a=%h b=%h sel=%b cin=%b got={f,co,v}=%b expected=%b",
                  req, a, b, op_sel, cin, got, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                        input logic [3:0] s, input logic c, input logic r, input logic l);
      @(negedge clk);
      a = ta; b = tb_; op_sel = s; cin = c; sri = r; sli = l;
      #1;
   endtask

   task automatic t_idle;
      apply('0, '0, 4'b0000, 1'b0, 1'b0, 1'b0);
      check("R1 idle zero", {f, cout, ovf}, '0);
   endtask

   // R1 R3 R4: every arithmetic code, both carries, all operands
   task automatic t_arith;
      for (int s = 0; s < 4; s++)
         for (int c = 0; c < 2; c++)
            for (int x = 0; x < N; x++)
               for (int y = 0; y < N; y++) begin
                  apply(W'(x), W'(y), 4'(s), c[0], 1'b0, 1'b0);
                  check("R1/R3/R4 arith", {f, cout, ovf},
                        model(W'(x), W'(y), 4'(s), c[0], 1'b0, 1'b0));
               end
   endtask

   // R5 R6 R7: other families, all codes, serial bits and cin toggled
   task automatic t_other;
      for (int s = 4; s < 16; s++)
         for (int c = 0; c < 2; c++)
            for (int x = 0; x < N; x++)
               for (int y = 0; y < N; y++) begin
                  apply(W'(x), W'(y), 4'(s), c[0], x[0] ^ c[0], y[0] ^ c[0]);
                  check(s < 8 ? "R5 logic" : (s < 12 ? "R6 shift right" : "R7 shift left"),
                        {f, cout, ovf},
                        model(W'(x), W'(y), 4'(s), c[0], x[0] ^ c[0], y[0] ^ c[0]));
               end
   endtask

   // R2: named operations
   task automatic t_named;
      apply(4'd5, 4'd6, 4'b0000, 1'b0, 1'b0, 1'b0); check("R2 add", {f, cout, ovf}, {4'd11, 1'b0, 1'b1});
      apply(4'd5, 4'd2, 4'b0000, 1'b1, 1'b0, 1'b0); check("R2 add plus one", {f, cout, ovf}, {4'd8, 1'b0, 1'b1});
      apply(4'd7, 4'd2, 4'b0001, 1'b0, 1'b0, 1'b0); check("R2 sub minus one", {f, cout, ovf}, {4'd4, 1'b1, 1'b0});
      apply(4'd9, 4'd9, 4'b0010, 1'b0, 1'b0, 1'b0); check("R2 transfer", {f, cout, ovf}, {4'd9, 1'b0, 1'b0});
      apply(4'd15, 4'd0, 4'b0010, 1'b1, 1'b0, 1'b0); check("R2 increment wrap", {f, cout, ovf}, {4'd0, 1'b1, 1'b0});
      apply(4'd0, 4'd0, 4'b0011, 1'b0, 1'b0, 1'b0); check("R2 decrement wrap", {f, cout, ovf}, {4'd15, 1'b0, 1'b0});
      apply(4'd6, 4'd3, 4'b0011, 1'b1, 1'b0, 1'b0); check("R2 transfer via ones", {f, cout, ovf}, {4'd6, 1'b1, 1'b0});
   endtask

   // R8: subtraction borrow corners
   task automatic t_sub;
      apply(4'd3, 4'd5, 4'b0001, 1'b1, 1'b0, 1'b0); check("R8 a<b", {f, cout}, {4'b1110, 1'b0});
      apply(4'd5, 4'd3, 4'b0001, 1'b1, 1'b0, 1'b0); check("R8 a>b", {f, cout}, {4'd2, 1'b1});
      apply(4'd8, 4'd8, 4'b0001, 1'b1, 1'b0, 1'b0); check("R8 a=b", {f, cout}, {4'd0, 1'b1});
      apply(4'b1101, 4'd5, 4'b0001, 1'b1, 1'b0, 1'b0); check("R8 signed -3-5", {f, cout, ovf}, {4'b1000, 1'b1, 1'b0});
      apply(4'b1000, 4'd1, 4'b0001, 1'b1, 1'b0, 1'b0); check("R4 signed -8-1", {f, cout, ovf}, {4'b0111, 1'b1, 1'b1});
   endtask

   // R6 R7: fixed patterns with serial inputs
   task automatic t_shift_fixed;
      apply(4'b1011, 4'b1111, 4'b1001, 1'b1, 1'b1, 1'b0); check("R6 serial in 1", {f, cout, ovf}, {4'b1101, 2'b00});
      apply(4'b1011, 4'b0000, 4'b1110, 1'b1, 1'b0, 1'b1); check("R7 serial in 1", {f, cout, ovf}, {4'b0111, 2'b00});
   endtask

   initial begin
      #1_500_000;
      n_fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #2;
      t_idle();
      t_named();
      t_sub();
      t_shift_fixed();
      t_arith();
      t_other();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule